// File: doc/BRIEF.md
# Biphase-Mark Serial Audio Frame Transmitter

This block turns a stream of stereo sample pairs into the single-wire consumer digital audio line (IEC 60958), coded in biphase-mark. Each frame holds a left subframe and then a right subframe. Each subframe has 32 slots, and each slot is two coding cells. The block clocks one cell per master clock cycle, so the master clock must run at 128 times the sample rate. At rates from 32 kHz to 192 kHz that master clock is the only timing reference.

Each subframe opens with a synchronisation preamble. Four payload slots close it: validity, user, channel status and parity. Between them sit 24 audio bits, least significant bit first. The channel-status bit is taken from one of two 192-bit stores, one for the left subframe and one for the right. A frame counter runs through a 192-frame block and selects the bit. Muting raises the validity flag and leaves the audio payload untouched. Samples come in through a one-entry valid/ready buffer. The buffer is drained at the start of every frame.

The block has two active-low resets. The output reset holds the line side idle and the input reset holds the sample side idle. The output reset is released first, then the input reset, and the enable is set last. Clearing the enable stops the line at once and restarts the framing.

Top module: `spdif_tx`

## Requirements
- R1: One frame lasts 128 clock cycles, one coding cell per cycle. Cells 0 to 63 carry the left subframe and cells 64 to 127 the right. Slot s of a subframe occupies its cells 2s and 2s+1.
- R2: Slots 0 to 3 carry an 8-cell preamble. With the line at 0 before it, the cells are 11101000 for the frame that starts a block, 11100010 for every other left subframe, and 11100100 for every right subframe. If the line was at 1 before the preamble, these cells are inverted.
- R3: Slots 4 to 27 carry the 24-bit sample, bit 0 in slot 4 and bit 23 in slot 27. The left word goes in the first subframe of the frame and the right word in the second.
- R4: In slots 4 to 31 the line toggles at the start of every slot. It toggles again at mid-slot when the slot's bit is 1.
- R5: Slot 31 is a parity bit that makes the bits of slots 4 to 31 contain an even number of ones. As a result the line ends each subframe at the level it had before that subframe's preamble.
- R6: Slot 28, the validity bit, equals the mute input in every subframe. The audio bits of slots 4 to 27 are still sent while mute is 1.
- R7: Slot 29, the user bit, is always 0.
- R8: Slot 30 carries bit f of the left store in the left subframe and bit f of the right store in the right subframe. Bit 0 is the least significant bit of each 192-bit vector, so 32-bit word 0 supplies bits 31..0. The frame index f runs from 0 to 191 and then wraps to 0. Frame 0 is the block-start frame.
- R9: If enable is 0 at a clock edge, the line is 0 after that edge and the frame position returns to cell 0 of frame 0. The next enable therefore starts with a block-start preamble.
- R10: Transmission needs both resets high and enable high. While the output reset is low the line is 0. While the input reset is low, sampleReady is 0, sampleValid is ignored and the sample buffer is cleared.
- R11: A sample pair is accepted on a clock edge with sampleValid and sampleReady both high. After that edge sampleReady is 0 until the buffer is drained at cell 0 of the next frame. That frame sends the buffered pair. If the buffer is empty at that point, the frame sends zero samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 128 times the sample rate |
| rstOutN | input | 1 | Active-low reset of the line side, released first |
| rstInN | input | 1 | Active-low reset of the sample side, released second |
| enable | input | 1 | Transmission enable, set last |
| mute | input | 1 | Value placed in the validity slot |
| sampleValid | input | 1 | Sample pair offered |
| sampleReady | output | 1 | Sample buffer is free |
| sampleLeft | input | 24 | Left sample word |
| sampleRight | input | 24 | Right sample word |
| chanStatA | input | BLOCK_FRAMES (192) | Channel-status bits for left subframes, bit f used in frame f |
| chanStatB | input | BLOCK_FRAMES (192) | Channel-status bits for right subframes, bit f used in frame f |
| spdifOut | output | 1 | Biphase-mark coded line |

## Verification
The sample patterns cover several cases: a lone bit at either end of the word, all ones against all zeros, alternating nibbles, and mixed words. These show whether bit order and left/right placement are correct, and whether the coder's mid-slot transitions and running polarity stay right when the parity comes out 0 and when it comes out 1. Muted frames carry nonzero audio, which tells a validity-only mute apart from one that zeroes the data. The channel-status stores differ between sides and at bits 0, 1 and 191. A run past frame 192 checks the block-start preamble against the plain left preamble and confirms that the status index wraps. Directed cases cover a sample offered during input reset, a mid-frame disable followed by a restart, and a frame with the buffer empty.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int AUDIO_W = 24;
  localparam int SLOT_W  = 5;
  localparam int CELL_W  = 7;   // 128 cells per frame

  // cell patterns (first cell in MSB) assuming the line sat at 0 before
  localparam logic [7:0] PRE_BLOCK = 8'b11101000;
  localparam logic [7:0] PRE_LEFT  = 8'b11100010;
  localparam logic [7:0] PRE_RIGHT = 8'b11100100;

  typedef struct packed {
    logic              run;
    logic              load;
    logic              rightSub;
    logic              blockStart;
    logic [SLOT_W-1:0] slot;
    logic              half;
  } strobe_t;
endpackage

// File: rtl/spdif_tx_ctrl.sv
module spdif_tx_ctrl
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  localparam int IDX_W = $clog2(BLOCK_FRAMES)
) (
  input  logic             clk,
  input  logic             rstOutN,
  input  logic             rstInN,
  input  logic             enable,
  output strobe_t          strb,
  output logic [IDX_W-1:0] frameIdx
);
  localparam logic [IDX_W-1:0]  LAST_FRAME = IDX_W'(BLOCK_FRAMES - 1);
  localparam logic [CELL_W-1:0] LAST_CELL  = '1;

  logic              active;
  logic [CELL_W-1:0] cellCnt;

  assign active = rstOutN & rstInN & enable;

  always_ff @(posedge clk or negedge rstOutN) begin
    if (!rstOutN) begin
      cellCnt  <= '0;
      frameIdx <= '0;
    end else if (!active) begin
      cellCnt  <= '0;
      frameIdx <= '0;
    end else begin
      cellCnt <= cellCnt + 1'b1;
      if (cellCnt == LAST_CELL)
        frameIdx <= (frameIdx == LAST_FRAME) ? '0 : frameIdx + 1'b1;
    end
  end

  always_comb begin
    strb.run        = active;
    strb.load       = active && (cellCnt == '0);
    strb.rightSub   = cellCnt[CELL_W-1];
    strb.blockStart = (frameIdx == '0);
    strb.slot       = cellCnt[CELL_W-2:1];
    strb.half       = cellCnt[0];
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstOutN)
    frameIdx <= LAST_FRAME); // R8
  AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rstOutN)
    (active && frameIdx == LAST_FRAME && cellCnt == LAST_CELL) |=> (frameIdx == '0)); // R8
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rstOutN)
    !active |=> (cellCnt == '0 && frameIdx == '0)); // R9
endmodule

// File: rtl/spdif_tx_dp.sv
module spdif_tx_dp
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  localparam int IDX_W = $clog2(BLOCK_FRAMES)
) (
  input  logic                    clk,
  input  logic                    rstOutN,
  input  logic                    rstInN,
  input  strobe_t                 strb,
  input  logic [IDX_W-1:0]        frameIdx,
  input  logic                    sampleValid,
  input  logic [AUDIO_W-1:0]      sampleLeft,
  input  logic [AUDIO_W-1:0]      sampleRight,
  input  logic                    mute,
  input  logic [BLOCK_FRAMES-1:0] chanStatA,
  input  logic [BLOCK_FRAMES-1:0] chanStatB,
  output logic                    sampleReady,
  output logic                    lineOut
);
  localparam logic [SLOT_W-1:0] FIRST_AUDIO = 5'd4;
  localparam logic [SLOT_W-1:0] SLOT_VALID  = 5'd28;
  localparam logic [SLOT_W-1:0] SLOT_USER   = 5'd29;
  localparam logic [SLOT_W-1:0] SLOT_STATUS = 5'd30;

  logic [AUDIO_W-1:0] pendL, pendR, curL, curR;
  logic               pendFull;
  logic               polReg;

  // ---------------- sample side ----------------
  assign sampleReady = rstInN & ~pendFull;

  always_ff @(posedge clk or negedge rstInN) begin
    if (!rstInN) begin
      pendL <= '0; pendR <= '0; curL <= '0; curR <= '0;
      pendFull <= 1'b0;
    end else begin
      if (strb.load) begin
        curL     <= pendFull ? pendL : '0;
        curR     <= pendFull ? pendR : '0;
        pendFull <= 1'b0;
      end
      if (sampleValid && sampleReady) begin
        pendL    <= sampleLeft;
        pendR    <= sampleRight;
        pendFull <= 1'b1;
      end
    end
  end

  // ---------------- slot contents ----------------
  logic [AUDIO_W-1:0] word, shifted;
  logic [SLOT_W-1:0]  dataIdx;
  logic               csBit, parityBit, slotBit;

  assign word      = strb.rightSub ? curR : curL;
  assign csBit     = strb.rightSub ? chanStatB[frameIdx] : chanStatA[frameIdx];
  assign parityBit = ^word ^ mute ^ csBit;   // user slot contributes 0
  assign dataIdx   = strb.slot - FIRST_AUDIO;
  assign shifted   = word >> dataIdx;

  always_comb begin
    if (strb.slot < SLOT_VALID)       slotBit = shifted[0];
    else if (strb.slot == SLOT_VALID) slotBit = mute;
    else if (strb.slot == SLOT_USER)  slotBit = 1'b0;
    else if (strb.slot == SLOT_STATUS) slotBit = csBit;
    else                              slotBit = parityBit;
  end

  // ---------------- biphase-mark coder ----------------
  logic       isPre;
  logic [2:0] preIdx;
  logic [7:0] prePat;
  logic       preBase, nextLine;

  assign isPre  = (strb.slot < FIRST_AUDIO);
  assign preIdx = {strb.slot[1:0], strb.half};
  assign prePat = strb.rightSub ? PRE_RIGHT : (strb.blockStart ? PRE_BLOCK : PRE_LEFT);

  always_comb begin
    preBase = (preIdx == 3'd0) ? lineOut : polReg;
    if (isPre)          nextLine = prePat[3'd7 - preIdx] ^ preBase;
    else if (!strb.half) nextLine = ~lineOut;
    else                nextLine = lineOut ^ slotBit;
  end

  always_ff @(posedge clk or negedge rstOutN) begin
    if (!rstOutN) begin
      lineOut <= 1'b0;
      polReg  <= 1'b0;
    end else if (!strb.run) begin
      lineOut <= 1'b0;
    end else begin
      lineOut <= nextLine;
      if (isPre && preIdx == 3'd0) polReg <= lineOut;
    end
  end

  AST_DATA_EDGE: assert property (@(posedge clk) disable iff (!rstOutN)
    (strb.run && !isPre && !strb.half) |=> (lineOut != $past(lineOut))); // R4
  AST_END_LEVEL: assert property (@(posedge clk) disable iff (!rstOutN)
    (strb.run && strb.slot == 5'd31 && strb.half) |=> (lineOut == $past(polReg))); // R5
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstOutN)
    !strb.run |=> !lineOut); // R9
  AST_IN_RESET: assert property (@(posedge clk) disable iff (!rstOutN)
    !rstInN |-> !sampleReady); // R10
  AST_HOLD_ACCEPT: assert property (@(posedge clk) disable iff (!rstInN)
    (sampleValid && sampleReady) |=> !sampleReady); // R11
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                    clk,
  input  logic                    rstOutN,
  input  logic                    rstInN,
  input  logic                    enable,
  input  logic                    mute,
  input  logic                    sampleValid,
  output logic                    sampleReady,
  input  logic [23:0]             sampleLeft,
  input  logic [23:0]             sampleRight,
  input  logic [BLOCK_FRAMES-1:0] chanStatA,
  input  logic [BLOCK_FRAMES-1:0] chanStatB,
  output logic                    spdifOut
);
  localparam int IDX_W = $clog2(BLOCK_FRAMES);

  strobe_t          strb;
  logic [IDX_W-1:0] frameIdx;

  spdif_tx_ctrl #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_ctrl (
    .clk(clk), .rstOutN(rstOutN), .rstInN(rstInN), .enable(enable),
    .strb(strb), .frameIdx(frameIdx)
  );

  spdif_tx_dp #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_dp (
    .clk(clk), .rstOutN(rstOutN), .rstInN(rstInN), .strb(strb),
    .frameIdx(frameIdx), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight), .mute(mute),
    .chanStatA(chanStatA), .chanStatB(chanStatB),
    .sampleReady(sampleReady), .lineOut(spdifOut)
  );
endmodule

// File: tb/sim_spdif_tx.sv
module sim_spdif_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NFR = 192;

  logic clk = 0, rstOutN = 0, rstInN = 0, enable = 0, mute = 0;
  logic sampleValid = 0, sampleReady, spdifOut;
  logic [23:0] sampleLeft = '0, sampleRight = '0;
  logic [NFR-1:0] chanStatA, chanStatB;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_tx u0 (
    .clk(clk), .rstOutN(rstOutN), .rstInN(rstInN), .enable(enable),
    .mute(mute), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .chanStatA(chanStatA), .chanStatB(chanStatB), .spdifOut(spdifOut)
  );

  // {mute, right, left}
  localparam logic [48:0] VEC [0:5] = '{
    {1'b0, 24'h5A5A5A, 24'h000001},
    {1'b0, 24'hFFFFFF, 24'h800000},
    {1'b1, 24'h123456, 24'hABCDEF},
    {1'b0, 24'h000000, 24'hFFFFFF},
    {1'b1, 24'h0F0F0F, 24'hF0F0F0},
    {1'b0, 24'h000001, 24'h7FFFFF}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // expected 64 cells of one subframe, cell 0 in bit 63, line at 0 before it
  function automatic logic [63:0] expSub(input logic [23:0] w, input logic m,
                                         input logic c, input logic [7:0] pre);
    logic [31:0] bits;
    logic [63:0] cells;
    logic prev, a, b;
    bits = '0;
    for (int i = 0; i < 24; i++) bits[4+i] = w[i];
    bits[28] = m; bits[29] = 1'b0; bits[30] = c;
    bits[31] = ^bits[30:4];
    for (int i = 0; i < 8; i++) cells[63-i] = pre[7-i];
    prev = pre[0];
    for (int s = 4; s < 32; s++) begin
      a = ~prev;
      b = bits[s] ? ~a : a;
      cells[63-2*s] = a;
      cells[62-2*s] = b;
      prev = b;
    end
    return cells;
  endfunction

  task automatic checkSub(input int k, input bit right, input logic [63:0] got,
                          input logic [23:0] w, input logic m);
    logic [63:0] exp;
    logic [7:0] pre;
    logic c;
    int f = k % NFR;
    pre = right ? 8'b11100100 : ((f == 0) ? 8'b11101000 : 8'b11100010);
    c = right ? chanStatB[f] : chanStatA[f];
    exp = expSub(w, m, c, pre);
    chk($sformatf("R1 R2 preamble frame %0d sub %0d", k, right), got & 64'hFF00_0000_0000_0000, exp & 64'hFF00_0000_0000_0000);
    chk($sformatf("R3 R4 audio frame %0d sub %0d", k, right), got & 64'h00FF_FFFF_FFFF_FF00, exp & 64'h00FF_FFFF_FFFF_FF00);
    chk($sformatf("R6 validity frame %0d sub %0d", k, right), got & 64'hC0, exp & 64'hC0);
    chk($sformatf("R7 user frame %0d sub %0d", k, right), got & 64'h30, exp & 64'h30);
    chk($sformatf("R8 status frame %0d sub %0d", k, right), got & 64'h0C, exp & 64'h0C);
    chk($sformatf("R5 parity frame %0d sub %0d", k, right), got & 64'h03, exp & 64'h03);
  endtask

  // caller's last action is at a negedge before the frame's first edge
  task automatic runFrame(input int k, input logic [48:0] cur, input bit doPush,
                          input logic [48:0] nxt);
    logic [127:0] cells;
    for (int j = 0; j < 128; j++) begin
      @(negedge clk);
      cells[127-j] = spdifOut;
      if (j == 0) mute = cur[48];
      if (j == 10 && doPush) begin
        sampleValid = 1; sampleLeft = nxt[23:0]; sampleRight = nxt[47:24];
      end
      if (j == 11 && doPush) begin
        sampleValid = 0;
        chk($sformatf("R11 ready low after accept frame %0d", k), 64'(sampleReady), 64'd0);
      end
    end
    checkSub(k, 0, cells[127:64], cur[23:0], cur[48]);
    checkSub(k, 1, cells[63:0], cur[47:24], cur[48]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    chanStatA = {6{32'h9000_0005}};  // bit0=1, bit191=1
    chanStatB = {6{32'h0000_0006}};  // bit0=0, bit1=1, bit191=0
    // both resets low, enable and a sample offered: all ignored (R10)
    enable = 1; sampleValid = 1; sampleLeft = 24'hDEAD01; sampleRight = 24'hBEEF02;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 line idle in reset", 64'(spdifOut), 64'd0);
      chk("R10 ready low in input reset", 64'(sampleReady), 64'd0);
    end
    @(negedge clk) rstOutN = 1;   // output side first
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 line idle while input reset low", 64'(spdifOut), 64'd0);
    end
    sampleValid = 0; rstInN = 1;  // input side second, enable already set
    runFrame(0, 49'd0, 0, 49'd0); // offered sample was ignored: zeros sent (R10)

    // mid-frame disable (R9)
    repeat (40) @(negedge clk);
    enable = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 line idle after disable", 64'(spdifOut), 64'd0);
    end
    sampleValid = 1; sampleLeft = VEC[0][23:0]; sampleRight = VEC[0][47:24];
    @(negedge clk);
    sampleValid = 0;
    chk("R11 ready low while buffer full", 64'(sampleReady), 64'd0);
    enable = 1;

    // table walk; frame 0 again proves the restart (R9)
    for (int v = 0; v < 6; v++)
      runFrame(v, VEC[v], (v < 5), (v < 5) ? VEC[v+1] : 49'd0);

    // empty buffer frames, through block wrap (R8, R11)
    for (int k = 6; k <= NFR; k++)
      runFrame(k, 49'd0, 0, 49'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule